// File: doc/BRIEF.md
# Serial Audio Decoder Feeder

The feeder takes one data word at a time from an upstream controller and sends it bit by bit to an external audio decoder chip over a single serial line. It makes the decoder's clock itself by dividing the system clock. It also drives the decoder's active-low reset. After any reset it holds the decoder in reset for a fixed number of chip-clock periods, then releases it and starts accepting words.

The upstream handshake works in four steps. The feeder raises a ready line. The controller asserts enable with a word present. The feeder captures the word and drops ready, and the controller takes that drop as completion. Ready stays low until every bit of the captured word has gone out.

The decoder throttles the stream through its demand input. While demand is low, the chip clock, the serial line and the bit position all freeze. Shifting resumes from the same bit when demand returns. Parameters set the word width, the clock division ratio and the length of the chip reset hold.

Top module: `bitstream_feeder`

## Requirements
- R1: While the synchronous reset input `rst` is high at a clock edge, after that edge `chipRstN` is 0, `wordReady` is 0, `chipClk` is 0 and `chipData` is 0.
- R2: After `rst` falls, `chipRstN` stays 0 for exactly RST_PERIODS*DIV clock cycles (8*5 = 40 by default), whatever the level of `chipDemand`. During that time `chipClk` makes RST_PERIODS rising edges. `chipRstN` and `wordReady` both go to 1 on the same edge that ends the hold, and `wordReady` is never 1 while `chipRstN` is 0.
- R3: A word is captured at a clock edge where `wordReady` and `wordEn` are both 1, and `wordReady` is 0 after that edge.
- R4: The bit seen on `chipData` at each rising edge of `chipClk` reproduces the captured word, most significant bit first, with exactly WIDTH rising edges per word.
- R5: `chipData` changes only on cycles where `chipClk` is 0, so the data is stable around each rising edge.
- R6: While demand is held high, `chipClk` has a period of DIV system cycles: it is high for DIV - DIV/2 cycles (3 by default) and low for DIV/2 cycles (2 by default).
- R7: While a word is being shifted, a clock edge with `chipDemand` at 0 changes neither `chipClk` nor `chipData`, and the word's progress does not advance.
- R8: After capture, `wordReady` stays 0 until exactly WIDTH*DIV clock edges with `chipDemand` at 1 have passed (80 by default), and returns to 1 on the last of them.
- R9: `wordEn` and `wordIn` have no effect while `wordReady` is 0: the word in flight goes out unchanged, and no new word is taken when it ends unless enable is then still high.
- R10: Raising `rst` in the middle of a word abandons that word. The serial line returns to 0 and the full reset hold of R2 restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset from the controller, active high |
| wordEn | input | 1 | Controller offers the word on `wordIn` |
| wordIn | input | WIDTH | Word to be serialized |
| wordReady | output | 1 | Feeder can take a word |
| chipDemand | input | 1 | Decoder asks for data; low pauses the stream |
| chipClk | output | 1 | Divided bit clock to the decoder |
| chipRstN | output | 1 | Active-low reset to the decoder |
| chipData | output | 1 | Serial data to the decoder, MSB first |

## Verification
A wrong bit counter or divider phase shows up at the ports within one word. Either a word comes back mis-assembled from the bits sampled at chip-clock rising edges, or ready returns after a number of demand-high cycles other than WIDTH*DIV. A pause that fails to freeze the state appears on the very next cycle as a change of the chip clock or data while demand is low. A reset hold counter that is off by one moves the release of the chip reset and of ready away from the 40th cycle after reset.

// File: rtl/feeder_pkg.sv
package feeder_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SHIFT = 2'd2
  } feedState_t;

  typedef struct packed {
    logic load;
    logic shift;
  } feedStrobes_t;

endpackage

// File: rtl/feeder_datapath.sv
module feeder_datapath
  import feeder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  feedStrobes_t     strobes,
  input  logic [WIDTH-1:0] wordIn,
  output logic             lastBit,
  output logic             chipData
);

  localparam int BIT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WIDTH - 1);

  logic [WIDTH-1:0] shiftReg;
  logic [BIT_W-1:0] bitCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobes.load) begin
      shiftReg <= wordIn;
      bitCnt   <= '0;
    end else if (strobes.shift) begin
      shiftReg <= {shiftReg[WIDTH-2:0], 1'b0};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  assign lastBit  = (bitCnt == BIT_LAST);
  assign chipData = shiftReg[WIDTH-1];

endmodule

// File: rtl/feeder_control.sv
module feeder_control
  import feeder_pkg::*;
#(
  parameter int DIV         = 5,
  parameter int RST_PERIODS = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wordEn,
  input  logic         chipDemand,
  input  logic         lastBit,
  output feedStrobes_t strobes,
  output logic         wordReady,
  output logic         chipClk,
  output logic         chipRstN
);

  localparam int DIV_W = $clog2(DIV + 1);
  localparam int RST_W = $clog2(RST_PERIODS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);
  localparam logic [DIV_W-1:0] RISE_AT  = DIV_W'(DIV / 2 - 1);
  localparam logic [RST_W-1:0] RST_LAST = RST_W'(RST_PERIODS - 1);

  feedState_t       state;
  logic [DIV_W-1:0] divCnt;
  logic [RST_W-1:0] rstCnt;
  logic             run;
  logic             periodEnd;

  always_comb begin
    run           = (state == ST_HOLD) || ((state == ST_SHIFT) && chipDemand);
    periodEnd     = run && (divCnt == DIV_LAST);
    strobes.load  = (state == ST_IDLE) && wordEn;
    strobes.shift = (state == ST_SHIFT) && periodEnd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HOLD;
      divCnt    <= '0;
      rstCnt    <= '0;
      chipClk   <= 1'b0;
      chipRstN  <= 1'b0;
      wordReady <= 1'b0;
    end else begin
      if (strobes.load) begin
        state     <= ST_SHIFT;
        divCnt    <= '0;
        wordReady <= 1'b0;
      end
      if (run) begin
        if (periodEnd) begin
          divCnt  <= '0;
          chipClk <= 1'b0;
        end else begin
          divCnt <= divCnt + 1'b1;
          if (divCnt == RISE_AT) chipClk <= 1'b1;
        end
      end
      if (periodEnd && (state == ST_HOLD)) begin
        if (rstCnt == RST_LAST) begin
          state     <= ST_IDLE;
          chipRstN  <= 1'b1;
          wordReady <= 1'b1;
        end else begin
          rstCnt <= rstCnt + 1'b1;
        end
      end
      if (strobes.shift && lastBit) begin
        state     <= ST_IDLE;
        wordReady <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/bitstream_feeder.sv
module bitstream_feeder
  import feeder_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int DIV         = 5,
  parameter int RST_PERIODS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wordEn,
  input  logic [WIDTH-1:0] wordIn,
  output logic             wordReady,
  input  logic             chipDemand,
  output logic             chipClk,
  output logic             chipRstN,
  output logic             chipData
);

  feedStrobes_t strobes;
  logic         lastBit;

  feeder_control #(.DIV(DIV), .RST_PERIODS(RST_PERIODS)) ctrl_i (
    .clk(clk), .rst(rst), .wordEn(wordEn), .chipDemand(chipDemand),
    .lastBit(lastBit), .strobes(strobes), .wordReady(wordReady),
    .chipClk(chipClk), .chipRstN(chipRstN)
  );

  feeder_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .wordIn(wordIn),
    .lastBit(lastBit), .chipData(chipData)
  );

endmodule

// File: rtl/feeder_checker.sv
module feeder_checker (
  input logic clk,
  input logic rst,
  input logic wordEn,
  input logic wordReady,
  input logic chipDemand,
  input logic chipClk,
  input logic chipRstN,
  input logic chipData
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!chipRstN && !wordReady && !chipClk && !chipData)); // R1

  AST_HOLD_NO_READY: assert property (@(posedge clk) disable iff (rst)
    !chipRstN |-> !wordReady); // R2

  AST_CAPTURE_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (wordReady && wordEn) |=> !wordReady); // R3

  AST_DATA_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(chipData) |-> !chipClk); // R5

  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!chipDemand && chipRstN && !wordReady) |=> ($stable(chipClk) && $stable(chipData))); // R7

endmodule

bind bitstream_feeder feeder_checker chk_i (
  .clk(clk), .rst(rst), .wordEn(wordEn), .wordReady(wordReady),
  .chipDemand(chipDemand), .chipClk(chipClk), .chipRstN(chipRstN),
  .chipData(chipData)
);

// File: tb/bitstream_feeder_tb.sv
module bitstream_feeder_tb_top;

  localparam int CLK_PERIOD  = 10;
  localparam int WIDTH       = 16;
  localparam int DIV         = 5;
  localparam int RST_PERIODS = 8;
  localparam int NVEC        = 5;
  // fields: word [24:9], pause length [8:1], ignore-enable test [0]
  localparam logic [24:0] VEC [NVEC] = '{
    {16'hA5C3, 8'd0, 1'b0},
    {16'h8001, 8'd3, 1'b0},
    {16'hFFFF, 8'd1, 1'b0},
    {16'h0000, 8'd5, 1'b1},
    {16'h1234, 8'd0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wordEn = 1'b0;
  logic [WIDTH-1:0] wordIn = '0;
  logic chipDemand = 1'b0;
  logic wordReady, chipClk, chipRstN, chipData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bitstream_feeder #(.WIDTH(WIDTH), .DIV(DIV), .RST_PERIODS(RST_PERIODS)) dut_i (
    .clk(clk), .rst(rst), .wordEn(wordEn), .wordIn(wordIn), .wordReady(wordReady),
    .chipDemand(chipDemand), .chipClk(chipClk), .chipRstN(chipRstN), .chipData(chipData)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // monitor
  logic demandAtEdge = 1'b0;
  logic rstAtEdge = 1'b1;
  always @(posedge clk) begin
    demandAtEdge <= chipDemand;
    rstAtEdge    <= rst;
  end

  logic [WIDTH-1:0] bits;
  int bitCount, freezeErr, edgeErr, cyc, riseCyc, riseGap, highLen;
  logic prevClk = 1'b0, prevData = 1'b0, prevReady = 1'b0, prevRstN = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (chipClk && !prevClk) begin
      bits = {bits[WIDTH-2:0], chipData};
      bitCount++;
      riseGap = cyc - riseCyc;
      riseCyc = cyc;
    end
    if (!chipClk && prevClk) highLen = cyc - riseCyc;
    if (!rstAtEdge && !demandAtEdge && prevRstN && !prevReady &&
        (chipClk != prevClk || chipData != prevData)) freezeErr++;
    if (!rstAtEdge && chipData != prevData && chipClk) edgeErr++;
    prevClk = chipClk; prevData = chipData; prevReady = wordReady; prevRstN = chipRstN;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // wait out the reset hold, counting cycles and chip clock rises
  task automatic waitHold(input string tag);
    int n = 0;
    int rises = 0;
    bit early = 1'b0;
    logic lastClk = 1'b0;
    while (!wordReady && n < 500) begin
      @(negedge clk);
      n++;
      if (chipClk && !lastClk && !chipRstN) rises++;
      lastClk = chipClk;
      if (!wordReady && chipRstN) early = 1'b1;
    end
    check(n == RST_PERIODS * DIV, {tag, " R2 hold length"}, n, RST_PERIODS * DIV);
    check(rises == RST_PERIODS, {tag, " R2 chip clock rises in hold"}, rises, RST_PERIODS);
    check(chipRstN && !early, {tag, " R2 reset released with ready"}, chipRstN, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!chipRstN && !wordReady && !chipClk && !chipData, "R1 reset outputs",
          {chipRstN, wordReady, chipClk, chipData}, 0);
    rst = 1'b0;          // demand stays low: hold must not depend on it
    waitHold("start");

    for (int v = 0; v < NVEC; v++) begin
      logic [WIDTH-1:0] w;
      int gap, active, k;
      bit ign, lastDem;
      w   = VEC[v][24:9];
      gap = int'(VEC[v][8:1]);
      ign = VEC[v][0];
      wordIn = w; wordEn = 1'b1; chipDemand = 1'b1;
      @(negedge clk);
      check(!wordReady, $sformatf("R3 ready drops on capture v%0d", v), wordReady, 0);
      bits = '0; bitCount = 0; freezeErr = 0; edgeErr = 0;
      wordEn = ign; wordIn = ~w;
      active = 0; k = 0; lastDem = 1'b1;
      while (!wordReady && k < 3000) begin
        chipDemand = !(gap > 0 && (k % (7 + gap)) >= 7);
        lastDem = chipDemand;
        @(negedge clk);
        k++;
        if (lastDem) active++;
        if (active >= WIDTH * DIV - 10) wordEn = 1'b0;
      end
      check(bits == w, $sformatf("R4 serial word v%0d", v), bits, w);
      check(bitCount == WIDTH, $sformatf("R4 bit count v%0d", v), bitCount, WIDTH);
      check(active == WIDTH * DIV, $sformatf("R8 busy demand cycles v%0d", v), active, WIDTH * DIV);
      check(edgeErr == 0, $sformatf("R5 data change on high clock v%0d", v), edgeErr, 0);
      if (gap > 0)
        check(freezeErr == 0, $sformatf("R7 pause freeze v%0d", v), freezeErr, 0);
      if (gap == 0 && !ign) begin
        check(riseGap == DIV, "R6 chip clock period", riseGap, DIV);
        check(highLen == DIV - DIV / 2, "R6 chip clock high time", highLen, DIV - DIV / 2);
      end
      if (ign) begin
        @(negedge clk);
        check(wordReady, $sformatf("R9 no capture while busy v%0d", v), wordReady, 1);
      end
    end

    // R10 reset in the middle of a word
    wordIn = 16'hFFFF; wordEn = 1'b1; chipDemand = 1'b1;
    @(negedge clk);
    wordEn = 1'b0;
    repeat (30) @(negedge clk);
    check(chipData == 1'b1, "R10 word in flight before reset", chipData, 1);
    rst = 1'b1;
    @(negedge clk);
    check(!chipRstN && !wordReady && !chipData, "R10 abort outputs",
          {chipRstN, wordReady, chipData}, 0);
    rst = 1'b0;
    waitHold("R10 rehold");
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule